// File: doc/BRIEF.md
# Configurable pixel bus router

The block steers three 10-bit video data buses onto one 24-bit pixel word that feeds a video encoder, and forwards one horizontal/vertical sync pair plus one subcarrier reference bit next to it. An 8-bit control byte, written by an external controller, decides how the word is packed. It also sets how many pixel clocks the pixel data lags the forwarded sync, and which sync pair and which reference source are passed on.

The control byte is registered on the pixel clock. The upper nibble carries the packing mode in bits [7:6] and the delay in bits [5:4]. The lower nibble carries the reference select in bit 1 and the sync select in bit 0. Bits [3:2] are reserved. Pixel data passes through one packing register and a tapped chain of three more registers. Sync and reference pass through a single register, so a delay of zero keeps data and sync aligned.

Top module: `pixel_bus_router`

## Requirements
- R1: While rst_ni is low, pix_o, hsync_o, vsync_o and ref_o are 0 and the registered control is 0, regardless of the clock.
- R2: Mode 2'b00 (ctrl_i[7:6]) gives pix_o = {14'b0, bus_a} one clock after the inputs; the delay field ctrl_i[5:4] has no effect in this mode.
- R3: Mode 2'b01 gives pix_o = {4'b0, bus_c, bus_b} one clock after the inputs, with no delay applied.
- R4: Mode 2'b10 gives pix_o = {bus_c, bus_a, bus_b[3:0]} one clock after the inputs, with no delay applied.
- R5: Mode 2'b11 gives pix_o = {14'b0, bus_a} taken 1 + D clocks after the inputs, where D = ctrl_i[5:4] (0 to 3).
- R6: hsync_o/vsync_o follow ext_hsync_i/ext_vsync_i when ctrl_i[0] is 0 and gen_hsync_i/gen_vsync_i when it is 1, one clock after the inputs.
- R7: ref_o follows bus_b_i[2] when ctrl_i[1] is 0 and gen_ref_i when it is 1, one clock after the inputs.
- R8: ctrl_i[3:2] has no effect on any output.
- R9: ctrl_i is sampled at a clock edge. The sampled value picks the packing and the sync/reference source for inputs captured at the next edge, and picks the delay tap at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 8 | Control byte: mode [7:6], delay [5:4], reserved [3:2], reference select [1], sync select [0] |
| bus_a_i | input | 10 | Input bus A |
| bus_b_i | input | 10 | Input bus B (bit 2 also serves as external reference) |
| bus_c_i | input | 10 | Input bus C |
| ext_hsync_i | input | 1 | Edge-connector horizontal sync |
| ext_vsync_i | input | 1 | Edge-connector vertical sync |
| gen_hsync_i | input | 1 | Genlock horizontal sync |
| gen_vsync_i | input | 1 | Genlock vertical sync |
| gen_ref_i | input | 1 | Genlock subcarrier reference |
| pix_o | output | 24 | Packed, optionally delayed pixel word |
| hsync_o | output | 1 | Forwarded horizontal sync |
| vsync_o | output | 1 | Forwarded vertical sync |
| ref_o | output | 1 | Forwarded subcarrier reference |

## Verification
On every cycle, the assertions check the sync and reference selection and the packing of each mode once the control byte has been steady for a few clocks. They also check the deepest delay tap of the delayed mode. The effect of a control change mid-stream can only be shown by the bench's scenarios, which compare every cycle with a history model. The same holds for the intermediate delay taps, the irrelevance of the reserved bits and the asynchronous reset mid-run.

// File: rtl/prb_pkg.sv
package prb_pkg;
  typedef enum logic [1:0] {
    MODE_A10     = 2'b00,
    MODE_CB20    = 2'b01,
    MODE_CAB24   = 2'b10,
    MODE_A10_DLY = 2'b11
  } pd_mode_e;

  // bit order mirrors ctrl_i
  typedef struct packed {
    pd_mode_e   mode;
    logic [1:0] dly;
    logic [1:0] rsvd;
    logic       ref_gen;
    logic       sync_gen;
  } ctrl_t;
endpackage

// File: rtl/prb_ctrl_reg.sv
module prb_ctrl_reg
  import prb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ctrl_t ctrl_i,
  output ctrl_t ctrl_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q_o <= '0;
    else         ctrl_q_o <= ctrl_i;
  end
endmodule

// File: rtl/prb_packer.sv
module prb_packer
  import prb_pkg::*;
#(
  parameter int BUS_W = 10,
  parameter int PIX_W = 24
) (
  input  pd_mode_e           mode_i,
  input  logic [BUS_W-1:0]   a_i,
  input  logic [BUS_W-1:0]   b_i,
  input  logic [BUS_W-1:0]   c_i,
  output logic [PIX_W-1:0]   pix_o
);
  localparam int LSB_W = PIX_W - 2*BUS_W;

  always_comb begin
    pix_o = '0;
    unique case (mode_i)
      MODE_A10, MODE_A10_DLY: pix_o[BUS_W-1:0] = a_i;
      MODE_CB20: begin
        pix_o[2*BUS_W-1:BUS_W] = c_i;
        pix_o[BUS_W-1:0]       = b_i;
      end
      MODE_CAB24: begin
        pix_o[PIX_W-1 -: BUS_W]       = c_i;
        pix_o[PIX_W-BUS_W-1 -: BUS_W] = a_i;
        pix_o[LSB_W-1:0]              = b_i[LSB_W-1:0];
      end
      default: pix_o = '0;
    endcase
  end
endmodule

// File: rtl/prb_delay_line.sv
module prb_delay_line #(
  parameter int W       = 24,
  parameter int MAX_DLY = 3,
  localparam int SEL_W  = (MAX_DLY < 1) ? 1 : $clog2(MAX_DLY + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     d_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [W-1:0]     q_o
);
  logic [W-1:0] stg [MAX_DLY+1];

  // stage 0 is the alignment register shared with the sync path
  for (genvar k = 0; k <= MAX_DLY; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg[k] <= '0;
      else if (k == 0) stg[k] <= d_i;
      else             stg[k] <= stg[(k == 0) ? 0 : k-1];
    end
  end

  always_comb begin
    if (int'(sel_i) > MAX_DLY) q_o = stg[MAX_DLY];
    else                       q_o = stg[sel_i];
  end
endmodule

// File: rtl/prb_sync_sel.sv
module prb_sync_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_gen_i,
  input  logic ref_gen_i,
  input  logic ext_h_i,
  input  logic ext_v_i,
  input  logic gen_h_i,
  input  logic gen_v_i,
  input  logic ext_ref_i,
  input  logic gen_ref_i,
  output logic h_o,
  output logic v_o,
  output logic ref_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_o   <= 1'b0;
      v_o   <= 1'b0;
      ref_o <= 1'b0;
    end else begin
      h_o   <= sync_gen_i ? gen_h_i : ext_h_i;
      v_o   <= sync_gen_i ? gen_v_i : ext_v_i;
      ref_o <= ref_gen_i ? gen_ref_i : ext_ref_i;
    end
  end
endmodule

// File: rtl/pixel_bus_router.sv
module pixel_bus_router
  import prb_pkg::*;
#(
  parameter int BUS_W       = 10,
  parameter int PIX_W       = 24,
  parameter int MAX_DLY     = 3,
  parameter int EXT_REF_BIT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       ctrl_i,
  input  logic [BUS_W-1:0] bus_a_i,
  input  logic [BUS_W-1:0] bus_b_i,
  input  logic [BUS_W-1:0] bus_c_i,
  input  logic             ext_hsync_i,
  input  logic             ext_vsync_i,
  input  logic             gen_hsync_i,
  input  logic             gen_vsync_i,
  input  logic             gen_ref_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             ref_o
);
  localparam int SEL_W = (MAX_DLY < 1) ? 1 : $clog2(MAX_DLY + 1);

  ctrl_t             ctrl_q;
  logic [PIX_W-1:0]  packed_pix;
  logic [SEL_W-1:0]  tap_sel;

  prb_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctrl_i  (ctrl_t'(ctrl_i)),
    .ctrl_q_o(ctrl_q)
  );

  prb_packer #(.BUS_W(BUS_W), .PIX_W(PIX_W)) u_pack (
    .mode_i(ctrl_q.mode),
    .a_i   (bus_a_i),
    .b_i   (bus_b_i),
    .c_i   (bus_c_i),
    .pix_o (packed_pix)
  );

  // only the delayed mode honours the delay field
  assign tap_sel = (ctrl_q.mode == MODE_A10_DLY) ? SEL_W'(ctrl_q.dly) : '0;

  prb_delay_line #(.W(PIX_W), .MAX_DLY(MAX_DLY)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (packed_pix),
    .sel_i (tap_sel),
    .q_o   (pix_o)
  );

  prb_sync_sel u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_gen_i(ctrl_q.sync_gen),
    .ref_gen_i (ctrl_q.ref_gen),
    .ext_h_i   (ext_hsync_i),
    .ext_v_i   (ext_vsync_i),
    .gen_h_i   (gen_hsync_i),
    .gen_v_i   (gen_vsync_i),
    .ext_ref_i (bus_b_i[EXT_REF_BIT]),
    .gen_ref_i (gen_ref_i),
    .h_o       (hsync_o),
    .v_o       (vsync_o),
    .ref_o     (ref_o)
  );
endmodule

// File: rtl/pixel_bus_router_chk.sv
module pixel_bus_router_chk #(
  parameter int BUS_W       = 10,
  parameter int PIX_W       = 24,
  parameter int EXT_REF_BIT = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       ctrl_i,
  input logic [BUS_W-1:0] bus_a_i,
  input logic [BUS_W-1:0] bus_b_i,
  input logic [BUS_W-1:0] bus_c_i,
  input logic             ext_hsync_i,
  input logic             ext_vsync_i,
  input logic             gen_hsync_i,
  input logic             gen_vsync_i,
  input logic             gen_ref_i,
  input logic [PIX_W-1:0] pix_o,
  input logic             hsync_o,
  input logic             vsync_o,
  input logic             ref_o
);
  localparam int LSB_W = PIX_W - 2*BUS_W;

  logic [2:0] n_edges;
  logic [2:0] n_stable;
  logic [7:0] ctrl_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_edges   <= '0;
      n_stable  <= '0;
      ctrl_prev <= '0;
    end else begin
      ctrl_prev <= ctrl_i;
      if (n_edges != 3'd7) n_edges <= n_edges + 3'd1;
      if (ctrl_i != ctrl_prev)   n_stable <= '0;
      else if (n_stable != 3'd7) n_stable <= n_stable + 3'd1;
    end
  end

  logic steady;
  assign steady = (n_edges >= 3'd6) && (n_stable >= 3'd5);

  AST_HSYNC_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_edges >= 3'd2) |-> hsync_o == ($past(ctrl_i[0], 2) ? $past(gen_hsync_i) : $past(ext_hsync_i))); // R6
  AST_VSYNC_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_edges >= 3'd2) |-> vsync_o == ($past(ctrl_i[0], 2) ? $past(gen_vsync_i) : $past(ext_vsync_i))); // R6
  AST_REF_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_edges >= 3'd2) |-> ref_o == ($past(ctrl_i[1], 2) ? $past(gen_ref_i) : $past(bus_b_i[EXT_REF_BIT]))); // R7
  AST_MODE_A10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady && $past(ctrl_i[7:6]) == 2'b00) |-> pix_o == PIX_W'($past(bus_a_i))); // R2
  AST_MODE_CB20: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady && $past(ctrl_i[7:6]) == 2'b01) |-> pix_o == PIX_W'({$past(bus_c_i), $past(bus_b_i)})); // R3
  AST_MODE_CAB24: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady && $past(ctrl_i[7:6]) == 2'b10) |->
      pix_o == {$past(bus_c_i), $past(bus_a_i), $past(bus_b_i[LSB_W-1:0])}); // R4
  AST_DLY_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady && $past(ctrl_i[7:4]) == 4'b1111) |-> pix_o == PIX_W'($past(bus_a_i, 4))); // R5
endmodule

bind pixel_bus_router pixel_bus_router_chk #(
  .BUS_W(BUS_W), .PIX_W(PIX_W), .EXT_REF_BIT(EXT_REF_BIT)
) u_chk (.*);

// File: tb/pixel_bus_router_tb.sv
module pixel_bus_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HIST       = 4096;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  ctrl_i = '0;
  logic [9:0]  bus_a_i = '0, bus_b_i = '0, bus_c_i = '0;
  logic        ext_hsync_i = 0, ext_vsync_i = 0, gen_hsync_i = 0, gen_vsync_i = 0, gen_ref_i = 0;
  logic [23:0] pix_o;
  logic        hsync_o, vsync_o, ref_o;

  int checks = 0;
  int errors = 0;
  int idx    = 0;
  logic [7:0]  c_h [HIST];
  logic [34:0] d_h [HIST];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pixel_bus_router u_dut (.*);

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // d fields: [34:25] A, [24:15] B, [14:5] C, [4] ext_h, [3] ext_v, [2] gen_h, [1] gen_v, [0] gen_ref
  function automatic logic [23:0] exp_pack(logic [7:0] c, logic [34:0] d);
    logic [9:0] a = d[34:25], b = d[24:15], cc = d[14:5];
    case (c[7:6])
      2'b01:   return {4'b0, cc, b};
      2'b10:   return {cc, a, b[3:0]};
      default: return {14'b0, a};
    endcase
  endfunction

  function automatic int eff_dly(logic [7:0] c);
    return (c[7:6] == 2'b11) ? int'(c[5:4]) : 0;
  endfunction

  task automatic chk(string req, string what, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at step %0d: actual %h expected %h", req, what, idx, act, exp);
    end
  endtask

  task automatic step(logic [7:0] c);
    logic [34:0] d;
    string tag;
    int k;
    d = {$urandom(), $urandom()};
    ctrl_i = c;
    {bus_a_i, bus_b_i, bus_c_i, ext_hsync_i, ext_vsync_i, gen_hsync_i, gen_vsync_i, gen_ref_i} = d;
    c_h[idx] = c;
    d_h[idx] = d;
    @(posedge clk_i);
    @(negedge clk_i);
    if (idx >= 4) begin
      k = eff_dly(c_h[idx]);
      if (c_h[idx][7:4] != c_h[idx-1][7:4])      tag = "R9";
      else if (c_h[idx][3:2] != c_h[idx-1][3:2]) tag = "R8";
      else case (c_h[idx][7:6])
        2'b00: tag = "R2";
        2'b01: tag = "R3";
        2'b10: tag = "R4";
        default: tag = "R5";
      endcase
      chk(tag, "pix", pix_o, exp_pack(c_h[idx-1-k], d_h[idx-k]));
      chk("R6", "hsync", 24'(hsync_o),
          24'(c_h[idx-1][0] ? d_h[idx][2] : d_h[idx][4]));
      chk("R6", "vsync", 24'(vsync_o),
          24'(c_h[idx-1][0] ? d_h[idx][1] : d_h[idx][3]));
      chk("R7", "ref", 24'(ref_o),
          24'(c_h[idx-1][1] ? d_h[idx][0] : d_h[idx][17]));
    end
    idx++;
  endtask

  task automatic reset_check();
    chk("R1", "pix in reset", pix_o, 24'h0);
    chk("R1", "sync/ref in reset", {21'b0, hsync_o, vsync_o, ref_o}, 24'h0);
  endtask

  initial begin
    logic [7:0] c;
    void'($urandom(32'h5EED_0193));
    repeat (3) @(negedge clk_i);
    reset_check();
    rst_ni = 1'b1;
    idx = 0;

    // directed: every mode and delay, including delays in the undelayed modes
    for (int m = 0; m < 4; m++) begin
      for (int dl = 0; dl < 4; dl++) begin
        c = {2'(m), 2'(dl), 2'b00, 2'(m + dl)};
        repeat (6) step(c);
        c[3:2] = 2'b11;             // R8: reserved bits toggled
        step(c);
        c[3:2] = 2'b01;
        step(c);
      end
    end

    // random control, changed now and then
    c = 8'($urandom());
    for (int n = 0; n < 1200; n++) begin
      if ($urandom_range(4) == 0) c = 8'($urandom());
      step(c);
    end

    // R1: asynchronous reset in mid-cycle
    #(CLK_PERIOD/4);
    rst_ni = 1'b0;
    #1;
    reset_check();
    @(negedge clk_i);
    reset_check();
    rst_ni = 1'b1;
    idx = 0;
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(3) == 0) c = {2'b11, 2'($urandom()), 4'($urandom())};
      step(c);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule